// File: doc/BRIEF.md
# Flash Bank Command Controller

This block interprets bus write cycles aimed at one bank of a parallel NOR-style flash memory and keeps track of the bank's operating mode. A write cycle is qualified by two active-low strobes, chip enable and write enable. Both strobes are sampled in the controller clock domain. Multi-cycle command sequences are decoded from these cycles. Each sequence starts with a two-cycle unlock. The decoded command then moves the bank between six modes: array read, identification (autoselect), program busy, erase busy, erase-suspended read and error.

When a program or sector-erase sequence completes, the block raises a one-cycle start pulse toward the embedded program/erase engine. With the pulse it gives the operation kind and the captured address. The engine reports back through a done input and a failure input. A failure raises the error status bit, and the bank then waits for a reset command. The reset command behaves differently in each mode:
- It cancels a partly entered sequence.
- It has no effect while an operation runs.
- It is the only exit from autoselect and from the error mode.
- It returns to erase-suspended read rather than plain read when the bank holds a suspended erase.

A read-side sector comparator marks any read that targets the sector whose erase is suspended. The block's edge carries only control and status signals, with no streamed data, so it has no valid/ready handshake. Each pin is a plain level or a one-cycle pulse.

Top module: `flash_bank_cmd`

## Requirements
- R1: After reset the mode output reads array-read (code 0), the error bit is 0, the erase hold output is 0, and no start pulse has been issued.
- R2: A bus cycle is active while both ce_n and we_n are low. Its address is the one present when the later of the two strobes falls. Its data is the value held until the first of the two strobes rises. Changes after that rise are ignored.
- R3: A command sequence opens with two unlock cycles: data AA at address 555h, then data 55 at address 2AAh (low 11 address bits compared, low 8 data bits used). Any cycle that does not match the expected next step returns the decoder to idle and leaves the mode unchanged.
- R4: After the unlock, data 90 at 555h enters autoselect (code 1). Every write except the reset command is then ignored.
- R5: After the unlock, data A0 at 555h followed by one cycle at any address gives a start pulse exactly one clock wide, with start_erase_o=0 and start_addr_o equal to that cycle's address. The mode becomes program busy (code 2).
- R6: Data 80 at 555h, then AA at 555h, then 55 at 2AAh, and finally 30 at any address starts a sector erase. This whole sequence follows the unlock and is accepted only from array-read. It gives a one-clock start pulse with start_erase_o=1, start_addr_o equal to the address of the final cycle, and the mode becomes erase busy (code 3).
- R7: The reset command (data F0, address ignored) written at any point of an unfinished sequence, including the program data cycle, cancels it without a start pulse. The bank ends in array-read, or in erase-suspended read if an erase is suspended.
- R8: In program busy or erase busy, reset and all sequences are ignored and no start pulse is given. engine done ends program busy in array-read, or in erase-suspended read if an erase is suspended. engine done ends erase busy in array-read.
- R9: Data B0 during erase busy enters erase-suspended read (code 4) and sets erase_hold_o. Data 30 in erase-suspended read resumes erase busy and clears erase_hold_o. An erase sequence is refused while suspended.
- R10: engine fail during either busy mode enters error (code 5) with dq5_o=1. The bank stays there through any write except reset. Reset clears dq5_o and returns to array-read, or to erase-suspended read if an erase is suspended.
- R11: rd_hit_o is 1 exactly when an erase is suspended and rd_sector equals the top SECT_W address bits of the suspended erase's address.
- R12: Autoselect or a program entered from erase-suspended read returns to erase-suspended read, on reset or on engine done respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | ADDR_W | Bus write address |
| data | input | DATA_W | Bus write data |
| eng_done | input | 1 | Embedded engine finished successfully |
| eng_fail | input | 1 | Embedded engine reports failure |
| rd_sector | input | SECT_W | Sector of the current array read |
| mode_o | output | 3 | Mode: 0 read, 1 autoselect, 2 program busy, 3 erase busy, 4 erase-suspended read, 5 error |
| start_o | output | 1 | One-cycle start pulse for the engine |
| start_erase_o | output | 1 | Operation kind with the start pulse: 1 erase, 0 program |
| start_addr_o | output | ADDR_W | Address for the started operation |
| erase_hold_o | output | 1 | An erase is suspended |
| dq5_o | output | 1 | Error status bit |
| rd_hit_o | output | 1 | Current read targets the suspended sector |

## Verification
The in-line assertions check these properties on every clock:
- The start pulse never lasts two cycles and only leaves an idle mode.
- Program busy holds until the engine reports back.
- Autoselect holds until a reset command.
- The suspend flag and the error bit agree with the mode.
- The decoder is idle whenever the mode refuses sequences.

Other behaviour appears only in the bench's scenarios:
- which strobe edge captures the address and which captures the data;
- the result of each third-cycle code;
- the context-dependent landing mode after a reset or a done;
- the sector comparison.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_AUTOSEL = 3'd1,
    MODE_PROG    = 3'd2,
    MODE_ERASE   = 3'd3,
    MODE_ESUSP   = 3'd4,
    MODE_ERROR   = 3'd5
  } bank_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_AUTOSEL,
    CMD_PROG,
    CMD_ERASE,
    CMD_SUSPEND,
    CMD_RESUME
  } bank_cmd_e;

  localparam int CODE_W = 8;
  localparam int UNLK_W = 11;

  localparam logic [CODE_W-1:0] CODE_UNLK_A  = 8'hAA;
  localparam logic [CODE_W-1:0] CODE_UNLK_B  = 8'h55;
  localparam logic [CODE_W-1:0] CODE_RESET   = 8'hF0;
  localparam logic [CODE_W-1:0] CODE_IDENT   = 8'h90;
  localparam logic [CODE_W-1:0] CODE_PROG    = 8'hA0;
  localparam logic [CODE_W-1:0] CODE_ERSETUP = 8'h80;
  localparam logic [CODE_W-1:0] CODE_SECTOR  = 8'h30;
  localparam logic [CODE_W-1:0] CODE_SUSPEND = 8'hB0;

  localparam logic [UNLK_W-1:0] ADR_UNLK_A = 11'h555;
  localparam logic [UNLK_W-1:0] ADR_UNLK_B = 11'h2AA;

endpackage

// File: rtl/fcc_bus_cycle.sv
module fcc_bus_cycle #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cyc_valid_o,
  output logic [ADDR_W-1:0] cyc_addr_o,
  output logic [DATA_W-1:0] cyc_data_o
);

  logic              act;
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // both strobes low: the later falling edge opens the cycle
  assign act = !ce_n && !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) addr_q <= addr;
      if (act)           data_q <= data;
    end
  end

  // first rising strobe closes the cycle; data is the last active sample
  assign cyc_valid_o = act_q && !act;
  assign cyc_addr_o  = addr_q;
  assign cyc_data_o  = data_q;

endmodule

// File: rtl/fcc_seq_tracker.sv
module fcc_seq_tracker
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic [DATA_W-1:0] cyc_data_i,
  input  logic              seq_ok_i,
  input  logic              erase_ok_i,
  output bank_cmd_e         cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);

  typedef enum logic [2:0] {
    T_IDLE, T_UNL1, T_UNL2, T_PDATA, T_ESET, T_EUNL1, T_EUNL2
  } trk_state_e;

  trk_state_e        state_q, state_d;
  bank_cmd_e         cmd_d;
  logic [CODE_W-1:0] code;
  logic [UNLK_W-1:0] low_adr;
  logic              hit_a, hit_b, at_a;

  assign code    = cyc_data_i[CODE_W-1:0];
  assign low_adr = cyc_addr_i[UNLK_W-1:0];
  assign at_a    = (low_adr == ADR_UNLK_A);
  assign hit_a   = at_a && (code == CODE_UNLK_A);
  assign hit_b   = (low_adr == ADR_UNLK_B) && (code == CODE_UNLK_B);

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NONE;
    if (cyc_valid_i) begin
      state_d = T_IDLE;
      if (!seq_ok_i) begin
        if (code == CODE_RESET)        cmd_d = CMD_RESET;
        else if (code == CODE_SUSPEND) cmd_d = CMD_SUSPEND;
      end else if (code == CODE_RESET) begin
        cmd_d = CMD_RESET;
      end else begin
        case (state_q)
          T_IDLE: begin
            if (hit_a)                     state_d = T_UNL1;
            else if (code == CODE_SUSPEND) cmd_d = CMD_SUSPEND;
            else if (code == CODE_SECTOR)  cmd_d = CMD_RESUME;
          end
          T_UNL1:  if (hit_b) state_d = T_UNL2;
          T_UNL2: begin
            if (at_a && code == CODE_IDENT)                     cmd_d = CMD_AUTOSEL;
            else if (at_a && code == CODE_PROG)                 state_d = T_PDATA;
            else if (at_a && code == CODE_ERSETUP && erase_ok_i) state_d = T_ESET;
          end
          T_PDATA: cmd_d = CMD_PROG;
          T_ESET:  if (hit_a) state_d = T_EUNL1;
          T_EUNL1: if (hit_b) state_d = T_EUNL2;
          T_EUNL2: if (code == CODE_SECTOR) cmd_d = CMD_ERASE;
          default: state_d = T_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= T_IDLE;
      cmd_o      <= CMD_NONE;
      cmd_addr_o <= '0;
    end else begin
      state_q    <= state_d;
      cmd_o      <= cmd_d;
      cmd_addr_o <= cyc_addr_i;
    end
  end

  // R3: decoder never holds a partial sequence while the mode refuses one
  assert_idle_when_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ok_i |-> state_q == T_IDLE);

endmodule

// File: rtl/fcc_mode_ctrl.sv
module fcc_mode_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_cmd_e         cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  output bank_mode_e        mode_o,
  output logic              start_o,
  output logic              start_erase_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              hold_o,
  output logic [SECT_W-1:0] hold_sect_o,
  output logic              dq5_o
);

  bank_mode_e        mode_q, mode_d, idle_mode;
  logic              sus_q, sus_d, dq5_q, dq5_d, go, go_erase;
  logic              start_q, erase_q;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [ADDR_W-1:0] saddr_q;

  assign idle_mode = sus_q ? MODE_ESUSP : MODE_READ;

  always_comb begin
    mode_d   = mode_q;
    sus_d    = sus_q;
    sect_d   = sect_q;
    dq5_d    = dq5_q;
    go       = 1'b0;
    go_erase = 1'b0;
    case (mode_q)
      MODE_READ, MODE_ESUSP: begin
        if (cmd_i == CMD_AUTOSEL) begin
          mode_d = MODE_AUTOSEL;
        end else if (cmd_i == CMD_PROG) begin
          mode_d = MODE_PROG;
          go     = 1'b1;
        end else if (cmd_i == CMD_ERASE && mode_q == MODE_READ) begin
          mode_d   = MODE_ERASE;
          go       = 1'b1;
          go_erase = 1'b1;
          sect_d   = cmd_addr_i[ADDR_W-1 -: SECT_W];
        end else if (cmd_i == CMD_RESUME && mode_q == MODE_ESUSP) begin
          mode_d = MODE_ERASE;
          sus_d  = 1'b0;
        end
      end
      MODE_AUTOSEL: if (cmd_i == CMD_RESET) mode_d = idle_mode;
      MODE_PROG: begin
        if (eng_fail_i) begin
          mode_d = MODE_ERROR;
          dq5_d  = 1'b1;
        end else if (eng_done_i) begin
          mode_d = idle_mode;
        end
      end
      MODE_ERASE: begin
        if (eng_fail_i) begin
          mode_d = MODE_ERROR;
          dq5_d  = 1'b1;
        end else if (eng_done_i) begin
          mode_d = MODE_READ;
        end else if (cmd_i == CMD_SUSPEND) begin
          mode_d = MODE_ESUSP;
          sus_d  = 1'b1;
        end
      end
      MODE_ERROR: begin
        if (cmd_i == CMD_RESET) begin
          mode_d = idle_mode;
          dq5_d  = 1'b0;
        end
      end
      default: mode_d = MODE_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_READ;
      sus_q   <= 1'b0;
      sect_q  <= '0;
      dq5_q   <= 1'b0;
      start_q <= 1'b0;
      erase_q <= 1'b0;
      saddr_q <= '0;
    end else begin
      mode_q  <= mode_d;
      sus_q   <= sus_d;
      sect_q  <= sect_d;
      dq5_q   <= dq5_d;
      start_q <= go;
      if (go) begin
        erase_q <= go_erase;
        saddr_q <= cmd_addr_i;
      end
    end
  end

  assign mode_o        = mode_q;
  assign start_o       = start_q;
  assign start_erase_o = erase_q;
  assign start_addr_o  = saddr_q;
  assign hold_o        = sus_q;
  assign hold_sect_o   = sect_q;
  assign dq5_o         = dq5_q;

  // R5: start pulse is one clock wide
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R8: a start only ever leaves an idle mode
  assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ($past(mode_q) == MODE_READ || $past(mode_q) == MODE_ESUSP));

  // R8: program busy waits for the engine
  assert_prog_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PROG && !eng_done_i && !eng_fail_i) |=> mode_q == MODE_PROG);

  // R4: autoselect left only by reset
  assert_autosel_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_AUTOSEL && cmd_i != CMD_RESET) |=> mode_q == MODE_AUTOSEL);

  // R10: error bit tracks the error mode
  assert_dq5_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq5_q == (mode_q == MODE_ERROR));

  // R9: a suspended erase is never paired with read or erase busy
  assert_hold_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sus_q |-> (mode_q != MODE_READ && mode_q != MODE_ERASE));

endmodule

// File: rtl/flash_bank_cmd.sv
module flash_bank_cmd
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              eng_done,
  input  logic              eng_fail,
  input  logic [SECT_W-1:0] rd_sector,
  output logic [2:0]        mode_o,
  output logic              start_o,
  output logic              start_erase_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              erase_hold_o,
  output logic              dq5_o,
  output logic              rd_hit_o
);

  logic              cyc_valid;
  logic [ADDR_W-1:0] cyc_addr, cmd_addr;
  logic [DATA_W-1:0] cyc_data;
  bank_cmd_e         cmd;
  bank_mode_e        mode;
  logic              hold;
  logic [SECT_W-1:0] hold_sect;
  logic              seq_ok, erase_ok;

  assign seq_ok   = (mode == MODE_READ) || (mode == MODE_ESUSP);
  assign erase_ok = (mode == MODE_READ);

  fcc_bus_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .data(data),
    .cyc_valid_o(cyc_valid), .cyc_addr_o(cyc_addr), .cyc_data_o(cyc_data)
  );

  fcc_seq_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .cyc_valid_i(cyc_valid), .cyc_addr_i(cyc_addr), .cyc_data_i(cyc_data),
    .seq_ok_i(seq_ok), .erase_ok_i(erase_ok),
    .cmd_o(cmd), .cmd_addr_o(cmd_addr)
  );

  fcc_mode_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .cmd_i(cmd), .cmd_addr_i(cmd_addr),
    .eng_done_i(eng_done), .eng_fail_i(eng_fail),
    .mode_o(mode), .start_o(start_o), .start_erase_o(start_erase_o),
    .start_addr_o(start_addr_o), .hold_o(hold), .hold_sect_o(hold_sect),
    .dq5_o(dq5_o)
  );

  assign mode_o       = mode;
  assign erase_hold_o = hold;
  assign rd_hit_o     = hold && (rd_sector == hold_sect);

  // R11: a flagged read only exists while an erase is parked
  assert_hit_needs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_o |-> mode_o != 3'd0 && mode_o != 3'd3);

endmodule

// File: tb/test_flash_bank_cmd.sv
`timescale 1ns/1ps
module test_flash_bank_cmd;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          eng_done = 1'b0, eng_fail = 1'b0;
  logic [SW-1:0] rd_sector = '0;
  logic [2:0]    mode_o;
  logic          start_o, start_erase_o, erase_hold_o, dq5_o, rd_hit_o;
  logic [AW-1:0] start_addr_o;

  int n_chk = 0, n_fail = 0, n_start = 0;
  logic          last_erase = 1'b0;
  logic [AW-1:0] last_addr = '0;
  bit            done_flag = 1'b0;

  always #2.5 clk = ~clk;

  flash_bank_cmd #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW)) i_flash_bank_cmd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .data(data),
    .eng_done(eng_done), .eng_fail(eng_fail), .rd_sector(rd_sector),
    .mode_o(mode_o), .start_o(start_o), .start_erase_o(start_erase_o),
    .start_addr_o(start_addr_o), .erase_hold_o(erase_hold_o), .dq5_o(dq5_o),
    .rd_hit_o(rd_hit_o)
  );

  always @(negedge clk) if (rst_n && start_o) begin
    n_start++;
    last_erase = start_erase_o;
    last_addr  = start_addr_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock();
    bus_wr(16'h0555, 8'hAA);
    bus_wr(16'h02AA, 8'h55);
  endtask

  task automatic engine(input bit fail);
    @(negedge clk); eng_done = !fail; eng_fail = fail;
    @(negedge clk); eng_done = 1'b0; eng_fail = 1'b0;
    @(negedge clk);
  endtask

  task automatic erase_seq(input logic [AW-1:0] a);
    unlock();
    bus_wr(16'h0555, 8'h80);
    unlock();
    bus_wr(a, 8'h30);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    logic [AW-1:0] seq_a [6];
    logic [DW-1:0] seq_d [6];
    seq_a = '{16'h0555, 16'h02AA, 16'h0555, 16'h0555, 16'h02AA, 16'h4321};
    seq_d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 dq5", 32'(dq5_o), 0);
    chk("R1 hold", 32'(erase_hold_o), 0);
    chk("R1 start", 32'(start_o), 0);

    // R3/R4/R7 sweep of every third-cycle code
    for (int d = 0; d < 256; d++) begin
      unlock();
      bus_wr(16'h0555, 8'(d));
      chk("R4 third code", 32'(mode_o), (d == 8'h90) ? 1 : 0);
      bus_wr(16'h7FFF, 8'hF0);
      chk("R7 reset after third code", 32'(mode_o), 0);
    end
    chk("R7 no start from sweep", 32'(n_start), 0);

    // R2 address at later fall, data until first rise
    @(negedge clk); addr = 16'h0123; data = 8'h00; ce_n = 1'b0;
    @(negedge clk); addr = 16'h0555; we_n = 1'b0;
    @(negedge clk); addr = 16'h0000; data = 8'hAA;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); data = 8'h00;
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr(16'h02AA, 8'h55);
    bus_wr(16'h0555, 8'h90);
    chk("R2 capture edges", 32'(mode_o), 1);
    bus_wr(16'h0000, 8'hF0);
    @(negedge clk); addr = 16'h0555; data = 8'hAA; we_n = 1'b0;
    @(negedge clk); addr = 16'h0123; ce_n = 1'b0;
    @(negedge clk); addr = 16'h0555;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr(16'h02AA, 8'h55);
    bus_wr(16'h0555, 8'h90);
    chk("R2 early address ignored", 32'(mode_o), 0);

    // R4 autoselect persistence
    unlock(); bus_wr(16'h0555, 8'h90);
    unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h0100, 8'h12);
    chk("R4 ignores program", 32'(mode_o), 1);
    chk("R4 no start", 32'(n_start), 0);
    bus_wr(16'h1234, 8'hF0);
    chk("R4 reset exits", 32'(mode_o), 0);

    // R3 mismatches at each step
    for (int k = 0; k < 3; k++) begin
      bus_wr(16'h0555, 8'hAA);
      if (k == 0) bus_wr(16'h02AB, 8'h55); else bus_wr(16'h02AA, (k == 1) ? 8'h56 : 8'h55);
      if (k == 2) bus_wr(16'h0554, 8'h90); else bus_wr(16'h0555, 8'h90);
      chk("R3 mismatch keeps mode", 32'(mode_o), 0);
      bus_wr(16'h0555, 8'h90);
      chk("R3 decoder back to idle", 32'(mode_o), 0);
    end

    // R5/R8 program sweep
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] pa;
      pa = {3'(i), 13'(13'h0A5 + i * 97)};
      base = n_start;
      unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(pa, 8'(i * 37 + 1));
      chk("R5 one start", 32'(n_start - base), 1);
      chk("R5 kind", 32'(last_erase), 0);
      chk("R5 address", 32'(last_addr), 32'(pa));
      chk("R5 mode", 32'(mode_o), 2);
      bus_wr(16'h0000, 8'hF0);
      unlock(); bus_wr(16'h0555, 8'h90);
      chk("R8 busy ignores writes", 32'(mode_o), 2);
      engine(1'b0);
      chk("R8 done to read", 32'(mode_o), 0);
    end
    base = n_start;
    unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h0200, 8'hF0);
    chk("R7 reset as data", 32'(mode_o), 0);
    chk("R7 no start", 32'(n_start - base), 0);

    // R7 abort erase sequence at every position
    for (int p = 1; p <= 5; p++) begin
      base = n_start;
      for (int j = 0; j < p; j++) bus_wr(seq_a[j], seq_d[j]);
      bus_wr(16'hFFFF, 8'hF0);
      bus_wr(16'h4321, 8'h30);
      chk("R7 erase abort mode", 32'(mode_o), 0);
      chk("R7 erase abort start", 32'(n_start - base), 0);
    end

    // R6 erase
    base = n_start;
    erase_seq(16'hA123);
    chk("R6 one start", 32'(n_start - base), 1);
    chk("R6 kind", 32'(last_erase), 1);
    chk("R6 address", 32'(last_addr), 32'h0000A123);
    chk("R6 mode", 32'(mode_o), 3);
    bus_wr(16'h0000, 8'hF0);
    chk("R8 erase ignores reset", 32'(mode_o), 3);

    // R9 suspend, R11 sector flag
    bus_wr(16'h0000, 8'hB0);
    chk("R9 suspend mode", 32'(mode_o), 4);
    chk("R9 hold set", 32'(erase_hold_o), 1);
    for (int s = 0; s < 8; s++) begin
      rd_sector = 3'(s); #1;
      chk("R11 sector flag", 32'(rd_hit_o), (s == 5) ? 1 : 0);
    end
    base = n_start;
    erase_seq(16'h2000);
    chk("R9 erase refused", 32'(mode_o), 4);
    chk("R9 no erase start", 32'(n_start - base), 0);

    // R12 program and autoselect from suspend
    unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h2468, 8'h5A);
    chk("R12 program from suspend", 32'(mode_o), 2);
    chk("R12 program address", 32'(last_addr), 32'h00002468);
    engine(1'b0);
    chk("R12 done to suspended read", 32'(mode_o), 4);
    unlock(); bus_wr(16'h0555, 8'h90);
    chk("R12 autoselect", 32'(mode_o), 1);
    bus_wr(16'h0000, 8'hF0);
    chk("R12 reset to suspended read", 32'(mode_o), 4);

    // R10 failure while suspended
    unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h3000, 8'h01);
    engine(1'b1);
    chk("R10 error mode", 32'(mode_o), 5);
    chk("R10 dq5 set", 32'(dq5_o), 1);
    unlock(); bus_wr(16'h0555, 8'h90);
    chk("R10 error sticky", 32'(mode_o), 5);
    bus_wr(16'h0000, 8'hF0);
    chk("R10 reset to suspended read", 32'(mode_o), 4);
    chk("R10 dq5 cleared", 32'(dq5_o), 0);
    rd_sector = 3'd5; #1;
    chk("R11 flag kept", 32'(rd_hit_o), 1);

    // R9 resume, R10 erase failure
    bus_wr(16'h0000, 8'h30);
    chk("R9 resume mode", 32'(mode_o), 3);
    chk("R9 hold cleared", 32'(erase_hold_o), 0);
    chk("R11 flag cleared", 32'(rd_hit_o), 0);
    engine(1'b1);
    chk("R10 erase fail", 32'(mode_o), 5);
    engine(1'b0);
    chk("R10 done ignored in error", 32'(mode_o), 5);
    bus_wr(16'h0000, 8'hF0);
    chk("R10 reset to read", 32'(mode_o), 0);

    // R8 erase done
    erase_seq(16'h6000);
    engine(1'b0);
    chk("R8 erase done", 32'(mode_o), 0);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule